// File: doc/BRIEF.md
# Nonvolatile Write Unlock Controller

This block sits between a processor's register bus and a nonvolatile memory stub. It holds one control/status byte and decodes one key address that stores nothing. Software starts a programming operation by writing 0x55 and then 0xAA to the key address, then setting the write-start bit in the control byte. The write-enable bit must already be set before that write.

While the operation runs, `mem_busy` stalls the processor and drives the memory stub. The operation lasts `PROG_CYCLES` clock cycles, and the write-start bit then clears itself. A warm reset that arrives during an operation aborts it and sets a sticky error bit, so software can detect the lost write and retry.

Two named state machines do the work:

- **Key sequencer.** It has three states: `KS_IDLE`, `KS_GOT_FIRST` and `KS_ARMED`.
  - *first-key*: `KS_IDLE` goes to `KS_GOT_FIRST` on a key write of 0x55.
  - *second-key*: `KS_GOT_FIRST` goes to `KS_ARMED` on a key write of 0xAA.
  - *abort*: any other bus write from any state returns to `KS_IDLE`. This includes every control write, so a start attempt always uses up the armed state.
  - Warm reset also returns the sequencer to `KS_IDLE`.
- **Operation timer.** It has two states: `OP_IDLE` and `OP_PROG`.
  - *launch*: `OP_IDLE` goes to `OP_PROG` on an accepted start.
  - *finish*: `OP_PROG` goes to `OP_IDLE` when the cycle count reaches `PROG_CYCLES`.
  - *abort*: `OP_PROG` goes to `OP_IDLE` on warm reset.

Top module: `nvm_unlock_ctrl`

## Requirements
- R1: The asynchronous power-on reset `por_n` low clears every control bit. The control byte then reads 0x00, and `mem_busy`, `mem_rd` and `mem_kind` are 0.
- R2: The control byte at `CTRL_ADDR` reads back in this layout: bit7 program-space select, bit6 config select, bit5 always 0, bit4 erase select, bit3 error, bit2 write enable, bit1 write start/busy, bit0 read start. Bits 7, 6, 4 and 2 take the written value.
- R3: Reads of `KEY_ADDR` and of any unused address return 0x00. Key writes store nothing.
- R4: A control write with bit1=1 starts an operation only when three conditions hold: the two writes just before it were 0x55 and then 0xAA to `KEY_ADDR`, write enable was already 1, and no operation is running. `mem_busy` and bit1 are then high for exactly `PROG_CYCLES` cycles, starting the cycle after the write, and then clear.
- R5: Any other write between the steps breaks the sequence, and the start is ignored. Such writes include a wrong key byte, a write to an unused address, or a repeated 0x55. The key bytes must be exactly 0x55 then 0xAA.
- R6: A start attempt while write enable is 0 is ignored, yet it still uses up the unlock. A following start needs a fresh key sequence.
- R7: Control writes made while an operation runs have no effect on any bit.
- R8: A warm reset (`warm_rst` high at a clock edge) during an operation ends it and sets bit3. It also clears write enable and read start, and keeps bits 7, 6 and 4.
- R9: A warm reset while idle leaves bit3 unchanged. It still clears write enable and read start.
- R10: Bit3 clears only when 0 is written to it. Writing 1 to it, or an operation finishing normally, never sets it.
- R11: A control write with bit0=1 while idle raises `mem_rd` and bit0 for the following cycle only.
- R12: `mem_kind` presents {bit7, bit6, bit4} of the control byte to the memory stub.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle high |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| mem_busy | output | 1 | Operation in progress; processor stall |
| mem_rd | output | 1 | One-cycle read request |
| mem_kind | output | 3 | {program select, config select, erase} |

## Verification
The bench builds the block with `ADDR_W`=2, `CTRL_ADDR`=0, `KEY_ADDR`=1 and `PROG_CYCLES`=5. The short operation allows hundreds of full unlock-and-run sequences. It also lets the bench count the busy window cycle by cycle.

With this small setup, the bench sweeps all 256 values of the control byte against the computed readback and `mem_kind`. It also sweeps all 256 values of the first key byte and all 256 values of the second, and only 0x55 and 0xAA may launch an operation. The spare fourth address serves as the foreign write in the abort case.

// File: rtl/nvm_unlock_pkg.sv
package nvm_unlock_pkg;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_GOT_FIRST,
        KS_ARMED
    } key_state_e;

    typedef enum logic {
        OP_IDLE,
        OP_PROG
    } op_state_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam int BIT_PROG  = 7;
    localparam int BIT_CFG   = 6;
    localparam int BIT_ERASE = 4;
    localparam int BIT_ERR   = 3;
    localparam int BIT_WREN  = 2;
    localparam int BIT_WR    = 1;
    localparam int BIT_RD    = 0;

endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
    import nvm_unlock_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       warm_rst,
    input  logic       wr_any,
    input  logic       wr_key,
    input  logic [7:0] wdata,
    output logic       armed
);

    key_state_e state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        state_q <= KS_IDLE;
        else if (warm_rst) state_q <= KS_IDLE;
        else               state_q <= state_d;
    end

    // Any write that is not the expected next key byte aborts the sequence.
    always_comb begin
        state_d = state_q;
        if (wr_any) begin
            state_d = KS_IDLE;
            unique case (state_q)
                KS_IDLE: begin
                    if (wr_key && wdata == KEY_FIRST) begin
                        state_d = KS_GOT_FIRST;
                    end
                end
                KS_GOT_FIRST: begin
                    if (wr_key && wdata == KEY_SECOND) begin
                        state_d = KS_ARMED;
                    end
                end
                KS_ARMED: state_d = KS_IDLE;
                default:  state_d = KS_IDLE;
            endcase
        end
    end

    always_comb begin
        armed = (state_q == KS_ARMED);
    end

endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer
    import nvm_unlock_pkg::*;
#(
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic por_n,
    input  logic warm_rst,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

    op_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= OP_IDLE;
            cnt_q   <= '0;
        end else if (warm_rst) begin
            state_q <= OP_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            OP_IDLE: begin
                cnt_d = '0;
                if (start) state_d = OP_PROG;
            end
            OP_PROG: begin
                if (cnt_q == LAST) begin
                    state_d = OP_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = OP_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == OP_PROG);
    end

endmodule

// File: rtl/nvm_unlock_ctrl.sv
module nvm_unlock_ctrl
    import nvm_unlock_pkg::*;
#(
    parameter int               ADDR_W      = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 0,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 1,
    parameter int               PROG_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    output logic              mem_busy,
    output logic              mem_rd,
    output logic [2:0]        mem_kind
);

    logic prog_q, cfg_q, erase_q, err_q, wren_q, rd_q;
    logic armed, busy, start;
    logic wr_ctrl, wr_key;
    logic unused_wbit;

    assign unused_wbit = bus_wdata[5];
    assign wr_ctrl     = bus_we && (bus_addr == CTRL_ADDR);
    assign wr_key      = bus_we && (bus_addr == KEY_ADDR);
    assign start       = wr_ctrl && bus_wdata[BIT_WR] && wren_q && armed
                         && !busy && !warm_rst;

    nvm_key_seq u_key (
        .clk      (clk),
        .por_n    (por_n),
        .warm_rst (warm_rst),
        .wr_any   (bus_we),
        .wr_key   (wr_key),
        .wdata    (bus_wdata),
        .armed    (armed)
    );

    nvm_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk      (clk),
        .por_n    (por_n),
        .warm_rst (warm_rst),
        .start    (start),
        .busy     (busy)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            prog_q  <= 1'b0;
            cfg_q   <= 1'b0;
            erase_q <= 1'b0;
            err_q   <= 1'b0;
            wren_q  <= 1'b0;
            rd_q    <= 1'b0;
        end else if (warm_rst) begin
            err_q  <= err_q | busy;
            wren_q <= 1'b0;
            rd_q   <= 1'b0;
        end else if (wr_ctrl && !busy) begin
            prog_q  <= bus_wdata[BIT_PROG];
            cfg_q   <= bus_wdata[BIT_CFG];
            erase_q <= bus_wdata[BIT_ERASE];
            err_q   <= err_q & bus_wdata[BIT_ERR];
            wren_q  <= bus_wdata[BIT_WREN];
            rd_q    <= bus_wdata[BIT_RD];
        end else begin
            rd_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata = {prog_q, cfg_q, 1'b0, erase_q, err_q, wren_q, busy, rd_q};
        end
        mem_busy = busy;
        mem_rd   = rd_q;
        mem_kind = {prog_q, cfg_q, erase_q};
    end

endmodule

// File: rtl/nvm_unlock_ctrl_chk.sv
module nvm_unlock_ctrl_chk #(
    parameter int               ADDR_W    = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 0,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 1
) (
    input logic              clk,
    input logic              por_n,
    input logic              warm_rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic [7:0]        bus_rdata,
    input logic              mem_busy,
    input logic              mem_rd,
    input logic              err_q
);

    AST_START_FROM_CTRL_WRITE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(mem_busy) |-> $past(bus_we && bus_addr == CTRL_ADDR && bus_wdata[1])); // R4

    AST_BUSY_SHOWS_WR: assert property (@(posedge clk) disable iff (!por_n)
        (mem_busy && bus_addr == CTRL_ADDR) |-> bus_rdata[1]); // R4

    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (bus_addr == KEY_ADDR) |-> (bus_rdata == 8'h00)); // R3

    AST_RSVD_BIT_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        !bus_rdata[5]); // R2

    AST_WARM_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst && mem_busy) |=> (!mem_busy && err_q)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (err_q && !(bus_we && bus_addr == CTRL_ADDR && !bus_wdata[3])) |=> err_q); // R10

    AST_ERR_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!por_n)
        (!err_q && !(warm_rst && mem_busy)) |=> !err_q); // R9

    AST_RD_FROM_WRITE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(mem_rd) |-> $past(bus_we && bus_addr == CTRL_ADDR && bus_wdata[0])); // R11

endmodule

bind nvm_unlock_ctrl nvm_unlock_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .KEY_ADDR  (KEY_ADDR)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .warm_rst  (warm_rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .mem_busy  (mem_busy),
    .mem_rd    (mem_rd),
    .err_q     (err_q)
);

// File: tb/nvm_unlock_ctrl_tb.sv
module nvm_unlock_ctrl_tb;

    localparam int ADDR_W = 2;
    localparam int PROGC  = 5;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_KEY  = 2'd1;
    localparam logic [1:0] A_SPARE = 2'd3;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       warm_rst = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       mem_busy, mem_rd;
    logic [2:0] mem_kind;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    nvm_unlock_ctrl #(
        .ADDR_W(ADDR_W), .CTRL_ADDR(A_CTRL), .KEY_ADDR(A_KEY), .PROG_CYCLES(PROGC)
    ) u_dut (
        .clk(clk), .por_n(por_n), .warm_rst(warm_rst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .mem_busy(mem_busy), .mem_rd(mem_rd),
        .mem_kind(mem_kind)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_at(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_ctrl(input string req, input logic [7:0] exp);
        logic [7:0] v;
        rd_at(A_CTRL, v);
        check(req, v, exp);
    endtask

    task automatic warm_pulse();
        @(negedge clk);
        warm_rst = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0;
    endtask

    task automatic unlock_start(input logic [7:0] ctrl);
        wr(A_KEY, 8'h55);
        wr(A_KEY, 8'hAA);
        wr(A_CTRL, ctrl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_ctrl("R1 ctrl after por", 8'h00);
        check("R1 busy/rd/kind", {3'b0, mem_busy, mem_rd, mem_kind}, 8'h00);
        por_n = 1'b1;

        // R2 R11 R12: sweep every control byte without unlock
        for (int d = 0; d < 256; d++) begin
            wr(A_CTRL, 8'(d));
            chk_ctrl("R2 sweep readback", 8'(d) & 8'hD5);
            check("R12 kind", {5'b0, mem_kind}, {5'b0, d[7], d[6], d[4]});
            check("R11 rd pulse", {7'b0, mem_rd}, {7'b0, d[0]});
            @(negedge clk);
            check("R11 rd clears", {7'b0, mem_rd}, 8'h00);
        end
        // R3: key and spare reads
        wr(A_KEY, 8'h5A);
        rd_at(A_KEY, v);   check("R3 key reads zero", v, 8'h00);
        rd_at(A_SPARE, v); check("R3 spare reads zero", v, 8'h00);

        // R5: sweep first key byte
        for (int k = 0; k < 256; k++) begin
            wr(A_CTRL, 8'h04);
            wr(A_KEY, 8'(k));
            wr(A_KEY, 8'hAA);
            wr(A_CTRL, 8'h06);
            check("R5 first key sweep", {7'b0, mem_busy}, {7'b0, k == 8'h55});
            if (mem_busy) repeat (PROGC) @(negedge clk);
        end
        // R5: sweep second key byte
        for (int k = 0; k < 256; k++) begin
            wr(A_CTRL, 8'h04);
            wr(A_KEY, 8'h55);
            wr(A_KEY, 8'(k));
            wr(A_CTRL, 8'h06);
            check("R5 second key sweep", {7'b0, mem_busy}, {7'b0, k == 8'hAA});
            if (mem_busy) repeat (PROGC) @(negedge clk);
        end
        // R5: foreign write and repeated first key
        wr(A_CTRL, 8'h04);
        wr(A_KEY, 8'h55); wr(A_SPARE, 8'h00); wr(A_KEY, 8'hAA); wr(A_CTRL, 8'h06);
        check("R5 spare write aborts", {7'b0, mem_busy}, 8'h00);
        wr(A_KEY, 8'h55); wr(A_KEY, 8'h55); wr(A_KEY, 8'hAA); wr(A_CTRL, 8'h06);
        check("R5 repeated 55 aborts", {7'b0, mem_busy}, 8'h00);

        // R6: start without prior write enable, unlock consumed
        wr(A_CTRL, 8'h00);
        unlock_start(8'h06);
        check("R6 no wren no start", {7'b0, mem_busy}, 8'h00);
        chk_ctrl("R6 wren now set", 8'h04);
        wr(A_CTRL, 8'h06);
        check("R6 unlock consumed", {7'b0, mem_busy}, 8'h00);

        // R4: exact busy window
        unlock_start(8'h06);
        for (int i = 0; i < PROGC; i++) begin
            check("R4 busy during op", {7'b0, mem_busy}, 8'h01);
            chk_ctrl("R4 wr bit during op", 8'h06);
            @(negedge clk);
        end
        check("R4 busy ends", {7'b0, mem_busy}, 8'h00);
        chk_ctrl("R4 wr self clears, R10 no err", 8'h04);

        // R7: writes during op ignored
        unlock_start(8'h06);
        wr(A_CTRL, 8'hD9);
        repeat (PROGC) @(negedge clk);
        check("R7 busy over", {7'b0, mem_busy}, 8'h00);
        chk_ctrl("R7 ctrl unchanged", 8'h04);

        // R8: warm reset mid-operation
        wr(A_CTRL, 8'hD4);
        unlock_start(8'hD6);
        check("R8 op started", {7'b0, mem_busy}, 8'h01);
        warm_pulse();
        check("R8 op aborted", {7'b0, mem_busy}, 8'h00);
        chk_ctrl("R8 err set sel kept", 8'hD8);
        check("R12 kind kept", {5'b0, mem_kind}, 8'h07);

        // R9 R10: err behaviour
        warm_pulse();
        chk_ctrl("R9 idle warm keeps err", 8'hD8);
        wr(A_CTRL, 8'hDC);
        chk_ctrl("R10 write 1 keeps err", 8'hDC);
        wr(A_CTRL, 8'hD4);
        chk_ctrl("R10 write 0 clears err", 8'hD4);
        wr(A_CTRL, 8'h0C);
        chk_ctrl("R10 write 1 cannot set", 8'h04);
        wr(A_CTRL, 8'hD5);
        warm_pulse();
        chk_ctrl("R9 idle warm clears wren", 8'hD0);
        wr(A_CTRL, 8'h04);
        unlock_start(8'h06);
        repeat (PROGC) @(negedge clk);
        chk_ctrl("R10 completion no err", 8'h04);

        // R1: por mid-run
        wr(A_CTRL, 8'hD4);
        unlock_start(8'hD6);
        warm_pulse();
        @(negedge clk);
        por_n = 1'b0;
        #1;
        chk_ctrl("R1 por clears all", 8'h00);
        check("R1 kind cleared", {5'b0, mem_kind}, 8'h00);
        @(negedge clk);
        por_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule